// File: doc/BRIEF.md
# Queue Sequence-Counter Semaphore Unit

This unit sits beside a single command queue and owns a small bank of monotonic per-buffer sequence counters. Privileged software fills the queue with wait commands that carry a buffer index and a target sequence value. It then rings a doorbell. From then on the unit consumes commands through a valid/ready handshake.

A wait holds the queue until the selected counter is at or above its target. The wait then opens a critical section on that buffer. A later signal closes the section and bumps the counter by exactly one. The size of the bump does not depend on the target the wait carried. Because the test is greater-or-equal and counters only grow, a counter that has run ahead releases every wait at or below its value, so surplus signals never deadlock the queue.

Signals outside a section, a second wait on an open section, illegal opcodes and aborted waits all raise a sticky fault flag for the queue. Direct writes from the unprivileged side are refused and never reach a counter. A read port exposes the counters to that side.

Top module: `seq_sem_unit`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge) every counter reads zero, every section bit is clear, fault is low and cmd_ready is low.
- R2: The queue stays stopped, with cmd_ready low and any offered command left unconsumed, until doorbell is seen high at a clock edge. cmd_ready is then high from the following cycle.
- R3: A wait (cmd_op 2'b01) whose counter is already greater than or equal to cmd_value, compared unsigned, completes in the cycle after acceptance. cmd_ready is low for exactly that one cycle, and then the section bit of that buffer (sect_open[cmd_idx]) is set.
- R4: A wait whose target is above its counter keeps cmd_ready low for as long as the counter stays below the target.
- R5: An accepted signal (cmd_op 2'b10) on a buffer with an open section increments that counter by exactly one, whatever target its wait carried, and clears the section bit. A counter never changes in any other way.
- R6: A signal on a buffer with no open section sets fault and leaves the counter unchanged.
- R7: A wait on a buffer whose section is already open sets fault, does not stall the queue and leaves the counter unchanged.
- R8: Timeout high during a stalled wait aborts it: fault is set, the queue returns to the stopped state with cmd_ready low, no counter or section bit changes, and only a new doorbell restarts the queue.
- R9: A user write strobe (user_wr_en) never changes a counter. Each strobe cycle produces a user_wr_rej pulse in the next cycle.
- R10: cmd_op 2'b00 is a no-op with no effect on counters, sections or fault. cmd_op 2'b11 is illegal and sets fault.
- R11: Once set, fault stays high until reset.
- R12: rd_data shows the counter selected by rd_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| doorbell | input | 1 | Starts the stopped queue |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | 00 no-op, 01 wait, 10 signal, 11 illegal |
| cmd_idx | input | IDX_W (2) | Buffer index |
| cmd_value | input | CTR_W (64) | Target sequence value of a wait |
| timeout | input | 1 | Privileged abort of a stalled wait |
| user_wr_en | input | 1 | Unprivileged counter write attempt |
| user_wr_rej | output | 1 | Pulse reporting a refused write |
| rd_idx | input | IDX_W (2) | Counter select for reads |
| rd_data | output | CTR_W (64) | Selected counter value |
| sect_open | output | NUM_CTR (4) | Open critical-section bit per buffer |
| fault | output | 1 | Sticky queue fault flag |

## Verification
An unprivileged write strobe can land in the same cycle as an accepted signal on the same counter. The two paths must not merge: the write has to be refused, and the signal has to produce exactly one increment. The bench provokes this by raising user_wr_en together with a signal command on a buffer whose section it has just opened. In the following cycle it expects the counter to have advanced by one, user_wr_rej to be high and the section bit to be clear. A second overlap, timeout raised while a wait is still unmet, is judged by checking that no counter or section bit moved and that the queue needs a fresh doorbell.

// File: rtl/seq_sem_pkg.sv
package seq_sem_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_WAIT = 2'b01,
        OP_SIG  = 2'b10,
        OP_BAD  = 2'b11
    } sem_op_e;

    typedef enum logic [1:0] {
        Q_STOP = 2'b00,
        Q_RUN  = 2'b01,
        Q_WAIT = 2'b10
    } q_state_e;

endpackage

// File: rtl/seq_sem_bank.sv
module seq_sem_bank #(
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              inc_en,
    input  logic [IDX_W-1:0]                  inc_idx,
    input  logic                              open_set_en,
    input  logic [IDX_W-1:0]                  open_set_idx,
    output logic [NUM_CTR-1:0][CTR_W-1:0]     ctr_o,
    output logic [NUM_CTR-1:0]                open_o
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             open;
    } slot_t;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (inc_en && (inc_idx == IDX_W'(g))) begin
                slot_d.cnt  = slot_q.cnt + 1'b1;
                slot_d.open = 1'b0;
            end
            if (open_set_en && (open_set_idx == IDX_W'(g))) begin
                slot_d.open = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign ctr_o[g]  = slot_q.cnt;
        assign open_o[g] = slot_q.open;
    end

endmodule

// File: rtl/seq_sem_ctrl.sv
module seq_sem_ctrl
    import seq_sem_pkg::*;
#(
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              doorbell,
    input  logic                              cmd_valid,
    input  logic [1:0]                        cmd_op,
    input  logic [IDX_W-1:0]                  cmd_idx,
    input  logic [CTR_W-1:0]                  cmd_value,
    input  logic                              timeout,
    input  logic                              user_wr_en,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]     ctr,
    input  logic [NUM_CTR-1:0]                open,
    output logic                              cmd_ready,
    output logic                              fault,
    output logic                              user_wr_rej,
    output logic                              inc_en,
    output logic [IDX_W-1:0]                  inc_idx,
    output logic                              open_set_en,
    output logic [IDX_W-1:0]                  open_set_idx
);

    typedef struct packed {
        q_state_e         st;
        logic [IDX_W-1:0] widx;
        logic [CTR_W-1:0] wtgt;
        logic             fault;
        logic             rej;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  wait_met;

    assign wait_met = (ctr[r_q.widx] >= r_q.wtgt);

    always_comb begin
        r_d          = r_q;
        r_d.rej      = user_wr_en;
        inc_en       = 1'b0;
        inc_idx      = cmd_idx;
        open_set_en  = 1'b0;
        open_set_idx = r_q.widx;

        case (r_q.st)
            Q_STOP: begin
                if (doorbell) begin
                    r_d.st = Q_RUN;
                end
            end
            Q_RUN: begin
                if (cmd_valid) begin
                    case (sem_op_e'(cmd_op))
                        OP_NOP: ;
                        OP_WAIT: begin
                            if (open[cmd_idx]) begin
                                r_d.fault = 1'b1;
                            end else begin
                                r_d.st   = Q_WAIT;
                                r_d.widx = cmd_idx;
                                r_d.wtgt = cmd_value;
                            end
                        end
                        OP_SIG: begin
                            if (open[cmd_idx]) begin
                                inc_en = 1'b1;
                            end else begin
                                r_d.fault = 1'b1;
                            end
                        end
                        default: r_d.fault = 1'b1;
                    endcase
                end
            end
            Q_WAIT: begin
                if (wait_met) begin
                    open_set_en = 1'b1;
                    r_d.st      = Q_RUN;
                end else if (timeout) begin
                    r_d.fault = 1'b1;
                    r_d.st    = Q_STOP;
                end
            end
            default: r_d.st = Q_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: Q_STOP, widx: '0, wtgt: '0, fault: 1'b0, rej: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready   = (r_q.st == Q_RUN);
    assign fault       = r_q.fault;
    assign user_wr_rej = r_q.rej;

endmodule

// File: rtl/seq_sem_unit.sv
module seq_sem_unit #(
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned NUM_CTR = 4,
    localparam int unsigned IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               doorbell,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [CTR_W-1:0]   cmd_value,
    input  logic               timeout,
    input  logic               user_wr_en,
    output logic               user_wr_rej,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CTR_W-1:0]   rd_data,
    output logic [NUM_CTR-1:0] sect_open,
    output logic               fault
);

    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_all;
    logic [NUM_CTR-1:0]            open_all;
    logic                          inc_en;
    logic [IDX_W-1:0]              inc_idx;
    logic                          open_set_en;
    logic [IDX_W-1:0]              open_set_idx;

    seq_sem_ctrl #(
        .CTR_W   (CTR_W),
        .NUM_CTR (NUM_CTR),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .doorbell     (doorbell),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_idx      (cmd_idx),
        .cmd_value    (cmd_value),
        .timeout      (timeout),
        .user_wr_en   (user_wr_en),
        .ctr          (ctr_all),
        .open         (open_all),
        .cmd_ready    (cmd_ready),
        .fault        (fault),
        .user_wr_rej  (user_wr_rej),
        .inc_en       (inc_en),
        .inc_idx      (inc_idx),
        .open_set_en  (open_set_en),
        .open_set_idx (open_set_idx)
    );

    seq_sem_bank #(
        .CTR_W   (CTR_W),
        .NUM_CTR (NUM_CTR),
        .IDX_W   (IDX_W)
    ) bank_i (
        .clk          (clk),
        .rst          (rst),
        .inc_en       (inc_en),
        .inc_idx      (inc_idx),
        .open_set_en  (open_set_en),
        .open_set_idx (open_set_idx),
        .ctr_o        (ctr_all),
        .open_o       (open_all)
    );

    assign rd_data   = ctr_all[rd_idx];
    assign sect_open = open_all;

endmodule

// File: rtl/seq_sem_chk.sv
module seq_sem_chk
    import seq_sem_pkg::*;
#(
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned IDX_W   = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cmd_valid,
    input logic                          cmd_ready,
    input logic [1:0]                    cmd_op,
    input logic [IDX_W-1:0]              cmd_idx,
    input logic                          user_wr_en,
    input logic                          user_wr_rej,
    input logic                          fault,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr,
    input logic [NUM_CTR-1:0]            open
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!cmd_ready && !fault && (open == '0)));

    assert_wait_stalls_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_op == OP_WAIT) && !open[cmd_idx]) |=> !cmd_ready);

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_user_refused_R9: assert property (@(posedge clk) disable iff (rst)
        user_wr_en |=> user_wr_rej);

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (ctr[g] != $past(ctr[g]))) |-> (ctr[g] == $past(ctr[g]) + 1'b1));

        assert_legal_signal_only_R6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (ctr[g] != $past(ctr[g]))) |->
            $past(cmd_valid && cmd_ready && (cmd_op == OP_SIG) &&
                  (cmd_idx == IDX_W'(g)) && open[g]));
    end

endmodule

bind seq_sem_unit seq_sem_chk #(
    .CTR_W   (CTR_W),
    .NUM_CTR (NUM_CTR),
    .IDX_W   (IDX_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_idx     (cmd_idx),
    .user_wr_en  (user_wr_en),
    .user_wr_rej (user_wr_rej),
    .fault       (fault),
    .ctr         (ctr_all),
    .open        (open_all)
);

// File: tb/seq_sem_unit_tb.sv
`timescale 1ns/1ps
module seq_sem_unit_tb_top;

    localparam int CW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          doorbell = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'b00;
    logic [1:0]    cmd_idx = 2'b00;
    logic [CW-1:0] cmd_value = '0;
    logic          timeout = 1'b0;
    logic          user_wr_en = 1'b0;
    logic          user_wr_rej;
    logic [1:0]    rd_idx = 2'b00;
    logic [CW-1:0] rd_data;
    logic [3:0]    sect_open;
    logic          fault;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seq_sem_unit dut_i (
        .clk(clk), .rst(rst), .doorbell(doorbell), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_value(cmd_value), .timeout(timeout), .user_wr_en(user_wr_en),
        .user_wr_rej(user_wr_rej), .rd_idx(rd_idx), .rd_data(rd_data),
        .sect_open(sect_open), .fault(fault)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int i, output logic [CW-1:0] v);
        rd_idx = 2'(i);
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; doorbell = 1'b0; timeout = 1'b0; user_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ring();
        doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
    endtask

    // Offers a command at a falling edge and returns at the falling edge after acceptance.
    task automatic issue(input logic [1:0] op, input int idx, input logic [CW-1:0] val);
        cmd_op = op; cmd_idx = 2'(idx); cmd_value = val; cmd_valid = 1'b1;
        for (int n = 0; n < 50 && !cmd_ready; n++) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Wait then signal on one buffer; the wait target is already met.
    task automatic pair(input int idx, input logic [CW-1:0] tgt);
        issue(2'b01, idx, tgt);
        @(negedge clk);
        issue(2'b10, idx, '0);
    endtask

    task automatic t_reset_and_start();
        logic [CW-1:0] v;
        do_reset();
        chk("R1 ready after reset", CW'(cmd_ready), 0);
        chk("R1 fault after reset", CW'(fault), 0);
        chk("R1 sections after reset", CW'(sect_open), 0);
        for (int i = 0; i < 4; i++) begin
            rd(i, v);
            chk("R1 counter after reset", v, 0);
        end
        // an orphan signal offered while stopped must not be consumed
        cmd_op = 2'b10; cmd_idx = 2'd0; cmd_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 stopped ready", CW'(cmd_ready), 0);
        chk("R2 stopped no fault", CW'(fault), 0);
        cmd_valid = 1'b0;
        ring();
        chk("R2 ready after doorbell", CW'(cmd_ready), 1);
    endtask

    task automatic t_pair_semantics();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b01, 0, 64'd0);
        chk("R3 ready low one cycle", CW'(cmd_ready), 0);
        @(negedge clk);
        chk("R3 ready back", CW'(cmd_ready), 1);
        chk("R3 section open", CW'(sect_open), 64'h1);
        issue(2'b10, 0, '0);
        rd(0, v);
        chk("R5 increment", v, 1);
        chk("R5 section closed", CW'(sect_open), 0);
        pair(0, 64'd1);
        rd(0, v);
        chk("R5 equal target then +1", v, 2);
        pair(0, 64'd0);
        rd(0, v);
        chk("R5 below target still +1", v, 3);
        chk("R5 no fault", CW'(fault), 0);
        rd(1, v);
        chk("R12 other counter", v, 0);
        rd(0, v);
        chk("R12 selected counter", v, 3);
    endtask

    task automatic t_orphan_signal();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b10, 1, '0);
        chk("R6 fault on orphan", CW'(fault), 1);
        rd(1, v);
        chk("R6 counter unchanged", v, 0);
        repeat (5) @(negedge clk);
        chk("R11 fault sticky", CW'(fault), 1);
    endtask

    task automatic t_double_wait();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b01, 2, 64'd0);
        @(negedge clk);
        issue(2'b01, 2, 64'd0);
        chk("R7 fault on second wait", CW'(fault), 1);
        chk("R7 no stall", CW'(cmd_ready), 1);
        rd(2, v);
        chk("R7 counter unchanged", v, 0);
    endtask

    task automatic t_stall_timeout();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b01, 3, 64'd5);
        repeat (10) @(negedge clk);
        chk("R4 still stalled", CW'(cmd_ready), 0);
        timeout = 1'b1;
        @(negedge clk);
        timeout = 1'b0;
        chk("R8 fault on abort", CW'(fault), 1);
        chk("R8 stopped", CW'(cmd_ready), 0);
        chk("R8 section unchanged", CW'(sect_open), 0);
        rd(3, v);
        chk("R8 counter unchanged", v, 0);
        repeat (3) @(negedge clk);
        chk("R8 stays stopped", CW'(cmd_ready), 0);
        ring();
        chk("R8 doorbell restarts", CW'(cmd_ready), 1);
    endtask

    task automatic t_user_write();
        logic [CW-1:0] v;
        do_reset();
        ring();
        pair(0, 64'd0);
        user_wr_en = 1'b1;
        @(negedge clk);
        user_wr_en = 1'b0;
        chk("R9 reject pulse", CW'(user_wr_rej), 1);
        rd(0, v);
        chk("R9 counter unchanged", v, 1);
        @(negedge clk);
        chk("R9 pulse ends", CW'(user_wr_rej), 0);
    endtask

    task automatic t_opcodes();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b00, 1, 64'd7);
        chk("R10 nop no fault", CW'(fault), 0);
        chk("R10 nop no section", CW'(sect_open), 0);
        rd(1, v);
        chk("R10 nop counter", v, 0);
        issue(2'b11, 1, 64'd7);
        chk("R10 illegal faults", CW'(fault), 1);
    endtask

    task automatic t_collision();
        logic [CW-1:0] v;
        do_reset();
        ring();
        issue(2'b01, 1, 64'd0);
        @(negedge clk);
        user_wr_en = 1'b1;
        issue(2'b10, 1, '0);
        user_wr_en = 1'b0;
        rd(1, v);
        chk("R5 R9 single step under write", v, 1);
        chk("R9 reject during signal", CW'(user_wr_rej), 1);
        chk("R5 section closed", CW'(sect_open), 0);
        chk("R9 no fault", CW'(fault), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_and_start();
        t_pair_semantics();
        t_orphan_signal();
        t_double_wait();
        t_stall_timeout();
        t_user_write();
        t_opcodes();
        t_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule